// File: doc/BRIEF.md
# NAND Cached Page-Program Sequencer

This block sits on the host side of an 8-bit NAND flash bus and runs one page program for each accepted request. A request gives a 16-bit column, a 16-bit row, a byte count and a flag that marks the last page of a stream. The block opens the program with its setup opcode and sends four address bytes. It then waits a programmable number of idle clocks and streams the data bytes, which it pulls one per cycle from `wdata_i`. Last, it sends the confirm opcode. The confirm is the cached form for pages that more pages will follow, and the plain form for the last page.

After the confirm, the block watches the ready/busy line and then reads the status byte. For a cached page, it reports as soon as the die is ready to take more input. At that point only the result of the earlier operation is known. For the last page, it keeps polling until the array is idle, and then reports both the current and the previous result. A bus cycle is one clock. Each bus phase drives exactly one strobe, with the byte on `bus_dq_o` or with `bus_dq_i` sampled in the same cycle. If the busy line stays low too long, the operation ends with a timeout.

Top module: `nand_pgm_seq`

## Requirements
- R1: A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both high. The next cycle is a command cycle with byte 80h. It is followed at once by exactly four address cycles carrying col[7:0], col[15:8], row[7:0] and row[15:8], in that order.
- R2: Exactly `req_len_i` data cycles follow. Each one drives the current `wdata_i` and raises `data_take_o`, so the bytes leave in the order they are supplied. A length of 0 gives no data cycle.
- R3: Exactly `adl_wait_i` idle cycles separate the last address cycle from the first data cycle. When the length is 0, they separate it from the confirm instead.
- R4: The confirm command comes straight after the data. It is 15h when `req_last_i` was 0 and 10h when it was 1.
- R5: After the confirm, one cycle passes and then the block waits for `rb_i` = 1. It then issues command 70h, followed immediately by one read cycle. In the status byte, bit 0 is the current-operation fail, bit 1 is the previous-operation fail, bit 5 is array-ready and bit 6 is ready.
- R6: For a cached page, one status read showing ready = 1 completes the operation, whatever the array-ready bit is. It reports `fail_o` = 0 and `fail_prev_o` = bit 1. For the last page, the 70h plus read pair repeats until both ready and array-ready are 1. It then reports `fail_o` = bit 0 and `fail_prev_o` = bit 1.
- R7: `done_o` is a single-cycle pulse. `err_o` = `fail_o` | `fail_prev_o` | `timeout_o`. All result outputs are valid with `done_o` and hold until the next completion.
- R8: If `rb_i` stays low for more than `timeout_lim_i` cycles of the busy wait, the operation completes with `timeout_o` = 1 and `err_o` = 1. In that case both fail outputs are 0 and no status command is issued.
- R9: `req_ready_o` is high only while idle. While idle, no bus strobe is active. Requests presented during an operation are not taken.
- R10: At most one of `bus_cmd_o`, `bus_addr_o`, `bus_wr_o` and `bus_rd_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request taken when valid |
| req_col_i | input | 16 | Column address |
| req_row_i | input | 16 | Row address |
| req_len_i | input | LEN_W | Data byte count |
| req_last_i | input | 1 | Last page of the stream |
| adl_wait_i | input | 8 | Idle cycles between address and data |
| timeout_lim_i | input | TO_W | Busy-wait limit in cycles |
| wdata_i | input | 8 | Next data byte |
| data_take_o | output | 1 | Current data byte consumed |
| bus_cmd_o | output | 1 | Command cycle |
| bus_addr_o | output | 1 | Address cycle |
| bus_wr_o | output | 1 | Data-in cycle |
| bus_rd_o | output | 1 | Data-out cycle, `bus_dq_i` sampled |
| bus_dq_o | output | 8 | Byte driven to the flash |
| bus_dq_i | input | 8 | Byte read from the flash |
| rb_i | input | 1 | Ready/busy line, 1 = ready |
| done_o | output | 1 | Operation complete pulse |
| fail_o | output | 1 | Current operation failed |
| fail_prev_o | output | 1 | Previous cached operation failed |
| timeout_o | output | 1 | Busy wait timed out |
| err_o | output | 1 | Any error of the completed operation |

## Verification
The assertions check, on every cycle, the rules that hold whatever the flash does:
- strobes are exclusive and the idle state is quiet;
- the read cycle comes straight after 70h;
- a request leads straight to 80h, and no data appears right after an address when a wait is set;
- `done_o` is a pulse;
- error flags are consistent, and a timeout is clean.

The byte order on the bus, the exact length of the wait, the choice of confirm opcode, and the decoding of the status bits can only be shown by the bench's scenarios. So can repeated polling until the array is idle and the timeout path. Each of these scenarios runs against a behavioural flash model.

// File: rtl/nand_pgm_pkg.sv
package nand_pgm_pkg;
  localparam logic [7:0] OP_OPEN  = 8'h80;
  localparam logic [7:0] OP_CACHE = 8'h15;
  localparam logic [7:0] OP_FINAL = 8'h10;
  localparam logic [7:0] OP_STAT  = 8'h70;

  localparam int ST_FAIL  = 0;
  localparam int ST_FAILC = 1;
  localparam int ST_ARDY  = 5;
  localparam int ST_RDY   = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN, S_ADDR, S_ADL, S_DATA, S_CONF,
    S_WB, S_BUSY, S_STATC, S_STATR, S_DONE
  } seq_state_e;
endpackage

// File: rtl/nand_pgm_cnt.sv
module nand_pgm_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/nand_pgm_stat.sv
module nand_pgm_stat
  import nand_pgm_pkg::*;
(
  input  logic [7:0] stat_i,
  output logic       fail_o,
  output logic       failc_o,
  output logic       ardy_o,
  output logic       rdy_o
);
  assign fail_o  = stat_i[ST_FAIL];
  assign failc_o = stat_i[ST_FAILC];
  assign ardy_o  = stat_i[ST_ARDY];
  assign rdy_o   = stat_i[ST_RDY];
endmodule

// File: rtl/nand_pgm_seq.sv
module nand_pgm_seq
  import nand_pgm_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int TO_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [15:0]      req_col_i,
  input  logic [15:0]      req_row_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             req_last_i,
  input  logic [7:0]       adl_wait_i,
  input  logic [TO_W-1:0]  timeout_lim_i,
  input  logic [7:0]       wdata_i,
  output logic             data_take_o,
  output logic             bus_cmd_o,
  output logic             bus_addr_o,
  output logic             bus_wr_o,
  output logic             bus_rd_o,
  output logic [7:0]       bus_dq_o,
  input  logic [7:0]       bus_dq_i,
  input  logic             rb_i,
  output logic             done_o,
  output logic             fail_o,
  output logic             fail_prev_o,
  output logic             timeout_o,
  output logic             err_o
);
  localparam int MAX_LT = (LEN_W > TO_W) ? LEN_W : TO_W;
  localparam int CNT_W  = (MAX_LT > 8) ? MAX_LT : 8;

  seq_state_e state_q, state_d;
  logic [15:0]      col_q, row_q;
  logic [LEN_W-1:0] len_q;
  logic             last_q;
  logic [CNT_W-1:0] cnt;
  logic             st_fail, st_failc, st_ardy, st_rdy;
  logic             res_set, res_fail, res_prev, res_tmo;

  // one counter serves every timed state; it restarts on each state change
  nand_pgm_cnt #(.W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != state_d),
    .cnt_o  (cnt)
  );

  nand_pgm_stat i_stat (
    .stat_i  (bus_dq_i),
    .fail_o  (st_fail),
    .failc_o (st_failc),
    .ardy_o  (st_ardy),
    .rdy_o   (st_rdy)
  );

  wire len_zero  = (len_q == '0);
  wire addr_last = (cnt == CNT_W'(3));
  wire adl_last  = (cnt == CNT_W'(adl_wait_i) - CNT_W'(1));
  wire data_last = (cnt == CNT_W'(len_q) - CNT_W'(1));
  wire tmo_hit   = (cnt == CNT_W'(timeout_lim_i));
  wire repoll    = !st_rdy || (last_q && !st_ardy);

  always_comb begin
    state_d  = state_q;
    res_set  = 1'b0;
    res_fail = 1'b0;
    res_prev = 1'b0;
    res_tmo  = 1'b0;
    unique case (state_q)
      S_IDLE:  if (req_valid_i) state_d = S_OPEN;
      S_OPEN:  state_d = S_ADDR;
      S_ADDR:  if (addr_last) state_d = (adl_wait_i != '0) ? S_ADL :
                                        (len_zero ? S_CONF : S_DATA);
      S_ADL:   if (adl_last) state_d = len_zero ? S_CONF : S_DATA;
      S_DATA:  if (data_last) state_d = S_CONF;
      S_CONF:  state_d = S_WB;
      S_WB:    state_d = S_BUSY;
      S_BUSY: begin
        if (rb_i) state_d = S_STATC;
        else if (tmo_hit) begin
          state_d = S_DONE;
          res_set = 1'b1;
          res_tmo = 1'b1;
        end
      end
      S_STATC: state_d = S_STATR;
      S_STATR: begin
        if (repoll) state_d = S_STATC;
        else begin
          state_d  = S_DONE;
          res_set  = 1'b1;
          res_fail = last_q & st_fail;
          res_prev = st_failc;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      col_q       <= '0;
      row_q       <= '0;
      len_q       <= '0;
      last_q      <= 1'b0;
      fail_o      <= 1'b0;
      fail_prev_o <= 1'b0;
      timeout_o   <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && req_valid_i) begin
        col_q  <= req_col_i;
        row_q  <= req_row_i;
        len_q  <= req_len_i;
        last_q <= req_last_i;
      end
      if (res_set) begin
        fail_o      <= res_fail;
        fail_prev_o <= res_prev;
        timeout_o   <= res_tmo;
        err_o       <= res_fail | res_prev | res_tmo;
      end
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign bus_cmd_o   = (state_q == S_OPEN) || (state_q == S_CONF) || (state_q == S_STATC);
  assign bus_addr_o  = (state_q == S_ADDR);
  assign bus_wr_o    = (state_q == S_DATA);
  assign bus_rd_o    = (state_q == S_STATR);
  assign data_take_o = bus_wr_o;

  always_comb begin
    unique case (state_q)
      S_OPEN:  bus_dq_o = OP_OPEN;
      S_ADDR: begin
        unique case (cnt[1:0])
          2'd0:    bus_dq_o = col_q[7:0];
          2'd1:    bus_dq_o = col_q[15:8];
          2'd2:    bus_dq_o = row_q[7:0];
          default: bus_dq_o = row_q[15:8];
        endcase
      end
      S_DATA:  bus_dq_o = wdata_i;
      S_CONF:  bus_dq_o = last_q ? OP_FINAL : OP_CACHE;
      S_STATC: bus_dq_o = OP_STAT;
      default: bus_dq_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_pgm_seq_chk.sv
module nand_pgm_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       bus_cmd_o,
  input logic       bus_addr_o,
  input logic       bus_wr_o,
  input logic       bus_rd_o,
  input logic [7:0] bus_dq_o,
  input logic [7:0] adl_wait_i,
  input logic       done_o,
  input logic       fail_o,
  input logic       fail_prev_o,
  input logic       timeout_o,
  input logic       err_o
);
  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_cmd_o, bus_addr_o, bus_wr_o, bus_rd_o}));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !(bus_cmd_o || bus_addr_o || bus_wr_o || bus_rd_o || done_o));

  p_accept_open_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (bus_cmd_o && bus_dq_o == 8'h80 && !req_ready_o));

  p_adl_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_o && $stable(adl_wait_i) && adl_wait_i != 8'd0) |=> !bus_wr_o);

  p_rd_after_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_rd_o) |-> $past(bus_cmd_o && bus_dq_o == 8'h70));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_cover_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (fail_o || fail_prev_o || timeout_o)) |-> err_o);

  p_tmo_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o) |-> (!fail_o && !fail_prev_o));
endmodule

bind nand_pgm_seq nand_pgm_seq_chk i_chk (.*);

// File: tb/test_nand_pgm_seq.sv
`timescale 1ns/1ps
module test_nand_pgm_seq;
  localparam int LEN_W = 12;
  localparam int TO_W  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_last = 1'b0;
  logic [15:0] req_col = '0, req_row = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] adl_wait = 8'd0;
  logic [TO_W-1:0] tmo_lim = 16'd200;
  logic [7:0] wdata, dq_o, dq_i;
  logic data_take, b_cmd, b_addr, b_wr, b_rd, rb;
  logic done, fail, fail_prev, tmo, err;

  always #5 clk = ~clk;

  nand_pgm_seq #(.LEN_W(LEN_W), .TO_W(TO_W)) i_nand_pgm_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_col_i(req_col), .req_row_i(req_row), .req_len_i(req_len), .req_last_i(req_last),
    .adl_wait_i(adl_wait), .timeout_lim_i(tmo_lim), .wdata_i(wdata), .data_take_o(data_take),
    .bus_cmd_o(b_cmd), .bus_addr_o(b_addr), .bus_wr_o(b_wr), .bus_rd_o(b_rd),
    .bus_dq_o(dq_o), .bus_dq_i(dq_i), .rb_i(rb), .done_o(done), .fail_o(fail),
    .fail_prev_o(fail_prev), .timeout_o(tmo), .err_o(err));

  // flash model, updated away from the active edge
  logic m_rb = 1'b1, m_ardy = 1'b1, m_fail = 1'b0, m_failc = 1'b0, m_hang = 1'b0;
  int busy_cnt = 0, ardy_cnt = 0;
  assign rb   = m_rb;
  assign dq_i = {1'b0, m_rb, m_ardy, 3'b000, m_failc, m_fail};

  always @(negedge clk) begin
    if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) m_rb = 1'b1;
    end
    if (ardy_cnt > 0) begin
      ardy_cnt--;
      if (ardy_cnt == 0) m_ardy = 1'b1;
    end
    if (b_cmd && (dq_o == 8'h15 || dq_o == 8'h10)) begin
      m_rb = 1'b0; m_ardy = 1'b0;
      busy_cnt = m_hang ? 0 : (dq_o == 8'h15 ? 5 : 10);
      ardy_cnt = m_hang ? 0 : (dq_o == 8'h15 ? 40 : 16);
    end
  end

  // data source and bus monitor
  int widx = 0, ncyc = 0, nlog = 0;
  int  l_typ [0:255];
  logic [7:0] l_val [0:255];
  int  l_cyc [0:255];
  assign wdata = 8'hA0 + 8'(widx);

  always @(negedge clk) begin
    ncyc++;
    if (nlog < 256 && (b_cmd || b_addr || b_wr || b_rd)) begin
      l_typ[nlog] = b_cmd ? 0 : b_addr ? 1 : b_wr ? 2 : 3;
      l_val[nlog] = dq_o;
      l_cyc[nlog] = ncyc;
      nlog++;
    end
    if (data_take) widx++;
  end

  int checks = 0, errors = 0;
  logic r_fail, r_prev, r_tmo, r_err, r_ok;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] col, input logic [15:0] row,
                        input int len, input bit last, input int adl);
    int waited;
    @(negedge clk);
    nlog = 0; widx = 0;
    req_col = col; req_row = row; req_len = LEN_W'(len);
    req_last = last; adl_wait = 8'(adl); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 ready low during op", int'(req_ready), 0);
    waited = 0; r_ok = 1'b0;
    while (!done && waited < 3000) begin @(negedge clk); waited++; end
    if (done) r_ok = 1'b1;
    chk(r_ok, "R7 done seen", int'(r_ok), 1);
    r_fail = fail; r_prev = fail_prev; r_tmo = tmo; r_err = err;
    @(negedge clk);
    chk(done == 1'b0, "R7 done single pulse", int'(done), 0);
  endtask

  task automatic check_frame(input logic [15:0] col, input logic [15:0] row,
                             input int len, input bit last, input int adl);
    int gap;
    chk(l_typ[0] == 0 && l_val[0] == 8'h80, "R1 open cmd", int'(l_val[0]), 8'h80);
    chk(l_typ[1] == 1 && l_val[1] == col[7:0],  "R1 col lo",  int'(l_val[1]), int'(col[7:0]));
    chk(l_typ[2] == 1 && l_val[2] == col[15:8], "R1 col hi",  int'(l_val[2]), int'(col[15:8]));
    chk(l_typ[3] == 1 && l_val[3] == row[7:0],  "R1 row lo",  int'(l_val[3]), int'(row[7:0]));
    chk(l_typ[4] == 1 && l_val[4] == row[15:8], "R1 row hi",  int'(l_val[4]), int'(row[15:8]));
    for (int k = 0; k < len; k++)
      chk(l_typ[5+k] == 2 && l_val[5+k] == 8'(8'hA0 + k), "R2 data byte",
          int'(l_val[5+k]), 8'hA0 + k);
    gap = l_cyc[5] - l_cyc[4] - 1;
    chk(gap == adl, "R3 address-to-next gap", gap, adl);
    chk(l_typ[5+len] == 0 && l_val[5+len] == (last ? 8'h10 : 8'h15), "R4 confirm",
        int'(l_val[5+len]), last ? 8'h10 : 8'h15);
    chk(l_typ[6+len] == 0 && l_val[6+len] == 8'h70, "R5 status cmd", int'(l_val[6+len]), 8'h70);
    chk(l_typ[7+len] == 3 && l_cyc[7+len] == l_cyc[6+len] + 1, "R5 read follows",
        l_cyc[7+len] - l_cyc[6+len], 1);
  endtask

  function automatic int count_stat();
    int n = 0;
    for (int k = 0; k < nlog; k++) if (l_typ[k] == 0 && l_val[k] == 8'h70) n++;
    return n;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready in reset", int'(req_ready), 1);
    chk(!(b_cmd || b_addr || b_wr || b_rd || done), "R9 quiet in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !err && !done, "R9 idle after reset", int'(req_ready), 1);
  endtask

  task automatic t_cached_pass();
    m_fail = 1'b0; m_failc = 1'b0;
    run_op(16'h1234, 16'h5678, 4, 1'b0, 3);
    check_frame(16'h1234, 16'h5678, 4, 1'b0, 3);
    chk(count_stat() == 1, "R6 one poll for cached", count_stat(), 1);
    chk(!r_fail && !r_prev && !r_tmo && !r_err, "R7 clean cached result",
        {r_fail, r_prev, r_tmo, r_err}, 0);
  endtask

  task automatic t_cached_prevfail();
    m_fail = 1'b1; m_failc = 1'b1;
    run_op(16'h00FF, 16'hA5C3, 3, 1'b0, 0);
    check_frame(16'h00FF, 16'hA5C3, 3, 1'b0, 0);
    chk(r_prev && !r_fail, "R6 cached reports previous only", {r_fail, r_prev}, 2'b01);
    chk(r_err && !r_tmo, "R7 err from previous fail", {r_err, r_tmo}, 2'b10);
    m_fail = 1'b0; m_failc = 1'b0;
  endtask

  task automatic t_final_fail();
    m_fail = 1'b1; m_failc = 1'b0;
    run_op(16'h0800, 16'h0102, 2, 1'b1, 1);
    check_frame(16'h0800, 16'h0102, 2, 1'b1, 1);
    chk(count_stat() >= 2, "R6 polls until array ready", count_stat(), 2);
    chk(r_fail && !r_prev && r_err, "R6 final reports current fail",
        {r_fail, r_prev, r_err}, 3'b101);
    chk(fail == 1'b1 && err == 1'b1, "R7 result held after done", {fail, err}, 2'b11);
    m_fail = 1'b0;
  endtask

  task automatic t_zero_len();
    run_op(16'h0010, 16'h0020, 0, 1'b1, 2);
    chk(l_typ[5] == 0 && l_val[5] == 8'h10, "R2 no data when length 0", int'(l_val[5]), 8'h10);
    chk(l_cyc[5] - l_cyc[4] - 1 == 2, "R3 gap before confirm", l_cyc[5] - l_cyc[4] - 1, 2);
    chk(!r_err, "R7 clean zero-length", int'(r_err), 0);
  endtask

  task automatic t_timeout();
    m_hang = 1'b1; tmo_lim = 16'd20; m_fail = 1'b1; m_failc = 1'b1;
    run_op(16'h0001, 16'h0002, 1, 1'b0, 0);
    chk(r_tmo && r_err, "R8 timeout reported", {r_tmo, r_err}, 2'b11);
    chk(!r_fail && !r_prev, "R8 no fail on timeout", {r_fail, r_prev}, 0);
    chk(count_stat() == 0, "R8 no status after timeout", count_stat(), 0);
    m_hang = 1'b0; m_rb = 1'b1; m_ardy = 1'b1; m_fail = 1'b0; m_failc = 1'b0;
    tmo_lim = 16'd200;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_cached_pass();
    t_cached_prevfail();
    t_final_fail();
    t_zero_len();
    t_timeout();
    t_cached_pass();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule